// File: doc/BRIEF.md
# Saturating Double-to-Integer Converter

This block converts an IEEE-754 double-precision operand into an integer. The integer can be signed or unsigned, 64 or 32 bits wide. The fractional part is always dropped, so every conversion rounds toward zero. Three kinds of input cannot be represented in the destination type: values beyond its limits, infinities and NaN. These never produce an undefined or sentinel value. Values past either limit, and the infinities, clamp to the nearest limit of the destination type. NaN becomes zero. An invalid flag goes high whenever such a replacement changes the exactly truncated value.

The operand and the mode travel together on a valid/ready input stream. The result and the flag leave on a valid/ready output stream through a single register stage. The input is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The result appears on the output in the cycle after acceptance. While `out_valid` is high and `out_ready` is low, the result and the flag stay frozen and no new operand is taken. Full throughput of one conversion per cycle is kept as long as `out_ready` stays high.

32-bit results occupy the low word of `out_result`. Signed modes sign-extend the low word into the upper word, and unsigned modes fill the upper word with zeros.

Top module: `fcvt_sat_top`

## Requirements
- R1: An operand accepted at a rising edge (in_valid and in_ready high) produces out_valid in the next cycle. While out_valid is high and out_ready is low, out_result and out_invalid hold their values, and in_ready equals (not out_valid) or out_ready.
- R2: Finite in-range inputs convert to the integer obtained by discarding the fraction (truncation toward zero), with out_invalid low.
- R3: A NaN (exponent field all ones, fraction field nonzero) yields 0 with out_invalid high in every mode.
- R4: Mode 2'b00 (signed 64-bit): truncated values below -2^63 give 0x8000000000000000 and those above 2^63-1 give 0x7fffffffffffffff, flag high; exactly -2^63 converts without flag.
- R5: Mode 2'b01 (unsigned 64-bit): truncated values of -1 or less give 0 and those of 2^64 or more give all ones, flag high.
- R6: Mode 2'b10 (signed 32-bit): truncated values below -2^31 give 0xffffffff80000000 and those above 2^31-1 give 0x000000007fffffff, flag high; in-range results are sign-extended from bit 31.
- R7: Mode 2'b11 (unsigned 32-bit): negative truncated values give 0 and those of 2^32 or more give 0x00000000ffffffff, flag high; bits 63:32 are always 0.
- R8: +infinity gives the destination maximum and -infinity the destination minimum (0 in unsigned modes), flag high.
- R9: ±0, subnormals and any input of magnitude below 1 (including negative ones in unsigned modes) give 0 with out_invalid low.
- R10: out_invalid is high exactly when NaN handling or clamping replaced the truncated value.
- R11: The mode travels with its operand: each result uses the mode sampled together with that operand, independently of neighbouring operands.
- R12: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand stream valid |
| in_ready | output | 1 | Operand stream ready |
| in_op | input | 64 | Double-precision operand bits |
| in_mode | input | 2 | 00 signed 64, 01 unsigned 64, 10 signed 32, 11 unsigned 32 |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_result | output | 64 | Integer result (32-bit results extended) |
| out_invalid | output | 1 | Value replaced by clamping or NaN handling |

## Verification
Errors in the alignment shift or in the range comparison appear on `out_result` in the cycle after acceptance. They show most clearly at the power-of-two boundaries, where a result is off by a factor of two or is clamped one step too early or too late. A faulty output register or handshake shows up in two ways: a result changes while the stream is stalled, or a result is lost or repeated, which breaks the one-to-one pairing of accepted operands with delivered results. Every result the bench takes from the output is matched against its model in the cycle it appears and again in every stalled cycle after it.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int DBL_W  = 64;
  localparam int EXP_W  = 11;
  localparam int FRC_W  = 52;
  localparam int BIAS   = 1023;
  localparam int RES_W  = 64;
  localparam int NARROW = 32;

  typedef enum logic [1:0] {
    MODE_S64 = 2'b00,
    MODE_U64 = 2'b01,
    MODE_S32 = 2'b10,
    MODE_U32 = 2'b11
  } cvt_mode_e;

  function automatic logic mode_signed(input cvt_mode_e m);
    return (m == MODE_S64) || (m == MODE_S32);
  endfunction

  function automatic logic mode_narrow(input cvt_mode_e m);
    return (m == MODE_S32) || (m == MODE_U32);
  endfunction

  // Largest representable positive magnitude of the destination type.
  function automatic logic [RES_W-1:0] pos_limit(input cvt_mode_e m);
    int drop;
    drop = (mode_narrow(m) ? RES_W - NARROW : 0) + (mode_signed(m) ? 1 : 0);
    return {RES_W{1'b1}} >> drop;
  endfunction

  // Largest representable negative magnitude of the destination type.
  function automatic logic [RES_W-1:0] neg_limit(input cvt_mode_e m);
    if (!mode_signed(m)) return '0;
    return mode_narrow(m) ? (RES_W'(1) << (NARROW - 1)) : (RES_W'(1) << (RES_W - 1));
  endfunction
endpackage

// File: rtl/fcvt_classify.sv
module fcvt_classify
  import fcvt_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRC_W,
  parameter int BS = BIAS
) (
  input  logic [EW+FW:0] op,
  output logic           sign,
  output logic           is_nan,
  output logic           below_one,
  output logic [EW-1:0]  unb_exp,
  output logic [FW:0]    mant
);
  logic [EW-1:0] exp_f;
  logic [FW-1:0] frc_f;

  assign sign      = op[EW+FW];
  assign exp_f     = op[EW+FW-1:FW];
  assign frc_f     = op[FW-1:0];
  assign is_nan    = (&exp_f) && (|frc_f);
  // Zeros and subnormals also fall here: their magnitude is below one.
  assign below_one = exp_f < EW'(BS);
  assign unb_exp   = exp_f - EW'(BS);
  assign mant      = {1'b1, frc_f};
endmodule

// File: rtl/fcvt_align.sv
module fcvt_align
  import fcvt_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRC_W,
  parameter int OW = RES_W
) (
  input  logic [FW:0]   mant,
  input  logic [EW-1:0] unb_exp,
  input  logic          below_one,
  output logic [OW-1:0] mag,
  output logic          mag_big
);
  localparam int PAD = OW - FW - 1;

  logic [OW-1:0] wide;
  logic [EW-1:0] rsh;
  logic [EW-1:0] lsh;

  assign wide    = {{PAD{1'b0}}, mant};
  assign rsh     = EW'(FW) - unb_exp;
  assign lsh     = unb_exp - EW'(FW);
  // Infinity lands here too, since its exponent exceeds every width.
  assign mag_big = !below_one && (unb_exp >= EW'(OW));

  always_comb begin
    if (below_one || mag_big) begin
      mag = '0;
    end else if (unb_exp <= EW'(FW)) begin
      mag = wide >> rsh;
    end else begin
      mag = wide << lsh;
    end
  end
endmodule

// File: rtl/fcvt_saturate.sv
module fcvt_saturate
  import fcvt_pkg::*;
#(
  parameter int OW = RES_W
) (
  input  cvt_mode_e     mode,
  input  logic          sign,
  input  logic          is_nan,
  input  logic [OW-1:0] mag,
  input  logic          mag_big,
  output logic [OW-1:0] result,
  output logic          invalid
);
  logic [OW-1:0] hi_lim;
  logic [OW-1:0] lo_lim;
  logic          over_hi;
  logic          over_lo;
  logic [OW-1:0] exact;

  assign hi_lim  = pos_limit(mode);
  assign lo_lim  = neg_limit(mode);
  assign over_hi = !is_nan && !sign && (mag_big || (mag > hi_lim));
  assign over_lo = !is_nan &&  sign && (mag_big || (mag > lo_lim));
  assign exact   = sign ? (~mag + OW'(1)) : mag;

  always_comb begin
    if (is_nan) begin
      result = '0;
    end else if (over_hi) begin
      result = hi_lim;
    end else if (over_lo) begin
      result = ~lo_lim + OW'(1);
    end else begin
      result = exact;
    end
  end

  assign invalid = is_nan || over_hi || over_lo;
endmodule

// File: rtl/fcvt_sat_top.sv
module fcvt_sat_top
  import fcvt_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRC_W,
  parameter int OW = RES_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [EW+FW:0] in_op,
  input  logic [1:0]    in_mode,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_result,
  output logic          out_invalid
);
  logic          c_sign;
  logic          c_nan;
  logic          c_small;
  logic [EW-1:0] c_exp;
  logic [FW:0]   c_mant;
  logic [OW-1:0] a_mag;
  logic          a_big;
  logic [OW-1:0] s_res;
  logic          s_inv;
  logic          take;

  fcvt_classify #(.EW(EW), .FW(FW), .BS(BIAS)) u_cls (
    .op        (in_op),
    .sign      (c_sign),
    .is_nan    (c_nan),
    .below_one (c_small),
    .unb_exp   (c_exp),
    .mant      (c_mant)
  );

  fcvt_align #(.EW(EW), .FW(FW), .OW(OW)) u_aln (
    .mant      (c_mant),
    .unb_exp   (c_exp),
    .below_one (c_small),
    .mag       (a_mag),
    .mag_big   (a_big)
  );

  fcvt_saturate #(.OW(OW)) u_sat (
    .mode    (cvt_mode_e'(in_mode)),
    .sign    (c_sign),
    .is_nan  (c_nan),
    .mag     (a_mag),
    .mag_big (a_big),
    .result  (s_res),
    .invalid (s_inv)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_result  <= '0;
      out_invalid <= 1'b0;
    end else if (take) begin
      out_result  <= s_res;
      out_invalid <= s_inv;
    end
  end
endmodule

// File: rtl/fcvt_sat_chk.sv
module fcvt_sat_chk
  import fcvt_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_op,
  input logic [1:0]  in_mode,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_result,
  input logic        out_invalid
);
  logic        fire;
  logic [10:0] ex;
  logic        nan_in;

  assign fire   = in_valid && in_ready;
  assign ex     = in_op[62:52];
  assign nan_in = (&ex) && (|in_op[51:0]);

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_invalid));

  // R1
  accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R3
  nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && nan_in |=> out_result == 64'd0 && out_invalid);

  // R9
  tiny_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ex < 11'd1023 |=> out_result == 64'd0 && !out_invalid);

  // R5
  u64_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_mode == 2'b01 && in_op[63] && !nan_in && ex >= 11'd1023
    |=> out_result == 64'd0 && out_invalid);

  // R6
  s32_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_mode == 2'b10 |=> out_result[63:32] == {32{out_result[31]}});

  // R7
  u32_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_mode == 2'b11 |=> out_result[63:32] == 32'd0);
endmodule

bind fcvt_sat_top fcvt_sat_chk u_chk (.*);

// File: tb/fcvt_sat_top_tb.sv
`timescale 1ns/1ps
module fcvt_sat_top_tb;
  localparam real HALF = 2.5;
  localparam int  WD_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_op = '0;
  logic [1:0]  in_mode = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_result;
  logic        out_invalid;

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] q_res[$];
  bit          q_inv[$];
  string       q_tag[$];
  logic [63:0] q_op[$];

  always #HALF clk = ~clk;

  fcvt_sat_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_invalid(out_invalid)
  );

  // Behavioural model using real arithmetic.
  // R11 mode codes: 0 s64, 1 u64, 2 s32, 3 u32.
  function automatic void ref_conv(input logic [63:0] op, input logic [1:0] md,
                                   output logic [63:0] res, output bit inv);
    real r, t, top, bot;
    bit  sg, nar;
    sg  = (md == 2'd0) || (md == 2'd2);
    nar = md[1];
    if (op[62:52] == 11'h7ff && op[51:0] != 0) begin
      res = '0; inv = 1'b1; return;
    end
    r = $bitstoreal(op);
    t = (r < 0.0) ? $ceil(r) : $floor(r);
    top = nar ? (sg ? 2.0**31 : 2.0**32) : (sg ? 2.0**63 : 2.0**64);
    bot = sg ? (nar ? -(2.0**31) : -(2.0**63)) : 0.0;
    if (t >= top) begin
      inv = 1'b1;
      res = nar ? (sg ? 64'h7fffffff : 64'hffffffff)
                : (sg ? 64'h7fffffffffffffff : 64'hffffffffffffffff);
      return;
    end
    if (t < bot) begin
      inv = 1'b1;
      res = !sg ? 64'd0 : (nar ? 64'hffffffff80000000 : 64'h8000000000000000);
      return;
    end
    inv = 1'b0;
    if (t >= 2.0**63)          res = 64'h8000000000000000 | 64'(longint'(t - 2.0**63));
    else if (t == -(2.0**63))  res = 64'h8000000000000000;
    else                       res = 64'(longint'(t));
  endfunction

  function automatic string tag_of(input logic [63:0] op, input logic [1:0] md, input bit inv);
    real r;
    if (op[62:52] == 11'h7ff) return (op[51:0] != 0) ? "R3" : "R8";
    r = $bitstoreal(op);
    if (r < 1.0 && r > -1.0) return "R9";
    if (inv) begin
      case (md)
        2'd0: return "R4";
        2'd1: return "R5";
        2'd2: return "R6";
        default: return "R7";
      endcase
    end
    return "R2";
  endfunction

  task automatic fail_line(input string tg, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
    n_bad++;
    $display("FAIL %s %s actual=%h expected=%h", tg, what, act, exp);
  endtask

  task automatic compare_out();
    if (!out_valid) return;
    n_cmp++;
    if (q_res.size() == 0) begin
      fail_line("R1", "output without accepted operand", out_result, 64'd0);
      return;
    end
    if (out_result !== q_res[0])
      fail_line(q_tag[0], $sformatf("result op=%h", q_op[0]), out_result, q_res[0]);
    if (out_invalid !== q_inv[0])
      fail_line("R10", $sformatf("flag op=%h", q_op[0]), 64'(out_invalid), 64'(q_inv[0]));
  endtask

  task automatic step(input bit iv, input logic [63:0] op, input logic [1:0] md,
                      input int rdy_pct, output bit took);
    logic [63:0] er;
    bit ei;
    @(negedge clk);
    compare_out();
    in_valid  = iv;
    in_op     = op;
    in_mode   = md;
    out_ready = ($urandom % 100) < rdy_pct;
    #0.5;
    took = iv && in_ready;
    // R1: ready is high exactly when the output is empty or draining
    if (in_ready !== (!out_valid || out_ready)) begin
      n_cmp++;
      fail_line("R1", "in_ready", 64'(in_ready), 64'(!out_valid || out_ready));
    end
    if (out_valid && out_ready && q_res.size() != 0) begin
      void'(q_res.pop_front()); void'(q_inv.pop_front());
      void'(q_tag.pop_front()); void'(q_op.pop_front());
    end
    if (took) begin
      ref_conv(op, md, er, ei);
      q_res.push_back(er); q_inv.push_back(ei);
      q_tag.push_back(tag_of(op, md, ei)); q_op.push_back(op);
    end
  endtask

  task automatic send(input logic [63:0] op, input logic [1:0] md, input int rdy_pct);
    bit took = 1'b0;
    while (!took) step(1'b1, op, md, rdy_pct, took);
  endtask

  task automatic drain();
    bit dummy;
    for (int k = 0; k < 200 && (q_res.size() != 0 || out_valid); k++)
      step(1'b0, 64'd0, 2'd0, 70, dummy);
  endtask

  function automatic logic [63:0] rnd_op();
    logic [10:0] e;
    logic [51:0] f;
    f = {$urandom, $urandom};
    if ($urandom % 3 == 0) f = f >> ($urandom % 52);
    case ($urandom % 5)
      0: e = 11'($urandom);
      1, 2: e = 11'(1021 + ($urandom % 68));
      3: e = 11'(1052 + ($urandom % 14));
      default: e = ($urandom % 2) ? 11'h7ff : 11'h000;
    endcase
    return {1'($urandom), e, f};
  endfunction

  logic [63:0] dirs[24] = '{
    64'h0000000000000000, 64'h8000000000000000, 64'h3ff8000000000000, 64'hbff8000000000000,
    64'h43dfffffffffffff, 64'h43e0000000000000, 64'hc3e0000000000000, 64'hc3e0000000000001,
    64'h43efffffffffffff, 64'h43f0000000000000, 64'h41dfffffffc00000, 64'h41dfffffffe00000,
    64'h41e0000000000000, 64'hc1e0000000000000, 64'hc1e0000000200000, 64'h41efffffffe00000,
    64'h41f0000000000000, 64'h7ff0000000000000, 64'hfff0000000000000, 64'h7ff8000000000000,
    64'hfff0000000000001, 64'h0000000000000001, 64'hbfe0000000000000, 64'hbff0000000000000
  };

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", WD_CYCLES);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    // R12: reset state
    n_cmp++;
    if (out_valid !== 1'b0) fail_line("R12", "out_valid after reset", 64'(out_valid), 64'd0);
    n_cmp++;
    if (in_ready !== 1'b1) fail_line("R12", "in_ready after reset", 64'(in_ready), 64'd1);

    // R4 R5 R6 R7 R8 R9 boundaries in every mode, full throughput
    for (int m = 0; m < 4; m++)
      foreach (dirs[i]) send(dirs[i], 2'(m), 100);
    drain();

    // Same boundaries under heavy back-pressure (R1), mode changing per operand (R11)
    foreach (dirs[i]) send(dirs[i], 2'(i % 4), 30);
    drain();

    // Random operands, random modes, random stalls (R2 truncation among them)
    for (int n = 0; n < 4000; n++) begin
      bit dummy;
      send(rnd_op(), 2'($urandom), 60);
      if ($urandom % 5 == 0) step(1'b0, 64'd0, 2'd0, 60, dummy);
    end
    drain();

    if (q_res.size() != 0) begin
      n_cmp++;
      fail_line("R1", "results never delivered", 64'(q_res.size()), 64'd0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule